// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch address stream for a single-issue, in-order front end. In that front end every control transfer has exactly one architectural delay slot. It holds a current address and a next address. On an ordinary instruction it shifts the next address into the current one and steps the next address by one 32-bit word. On a control transfer, the word after the branch always issues as the delay slot. The redirect is written into the next address, so the target is fetched once the slot has issued.

Each cycle the decoder presents four things for the instruction at `pc`:
- whether it is a control transfer;
- its resolved direction;
- whether it is of the annulling kind, which cancels its slot on fall-through;
- the externally computed target.

An exception strobe may also arrive for the instruction currently issuing. A fault on a valid instruction is reported with a restart address and a flag that marks a delay slot. For a slot, the restart address is the branch that owns it. Fetch then restarts there, which discards the pending redirect so that the branch and its slot behave as one indivisible pair.

Top module: `delay_pc_sequencer`

## Requirements
- R1: While `rstN` is low, `pc` equals `RESET_VEC` (default 0x1000), `issueValid` is 1 and `excValid` is 0. The first advancing edge after release moves `pc` to `RESET_VEC + 4`.
- R2: On an advancing edge with no control transfer taking effect and no fault, the new `pc` is the old next address, and the next address grows by 4.
- R3: An effective control transfer at address A makes A+4 issue next with `issueValid` = 1. The word after that is the target if `brTaken` is 1, and A+8 otherwise.
- R4: An annulling transfer (`brLikely` = 1) that falls through drives `issueValid` to 0 for its slot, and a `fault` during that slot yields no `excValid`. If the transfer is taken, the slot issues with `issueValid` = 1.
- R5: A control transfer that sits in a delay slot redirects nothing. The address after it is the older branch's outcome, whatever its own `brTaken` and `brTarget` are.
- R6: A `fault` on a valid delay-slot instruction asserts `excValid` and `excInSlot`, and `excPc` is the branch's address. The following `pc` is that branch's address, with the pending redirect discarded.
- R7: A `fault` on a valid instruction outside a slot asserts `excValid` with `excPc` = `pc` and `excInSlot` = 0, and fetch restarts at that same `pc`.
- R8: While `stall` is 1, `pc`, the next address and the slot/annul state hold, and `excValid` stays 0.
- R9: Bits [1:0] of `brTarget` are ignored. Every `pc` value has bits [1:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Holds all sequencer state for this cycle |
| isBranch | input | 1 | Instruction at `pc` is a control transfer |
| brTaken | input | 1 | Resolved direction of that transfer |
| brLikely | input | 1 | Transfer annuls its slot when not taken |
| brTarget | input | ADDR_W | Redirect address for a taken transfer |
| fault | input | 1 | Instruction at `pc` raised an exception |
| pc | output | ADDR_W | Address of the instruction issuing now |
| issueValid | output | 1 | 0 when the issuing instruction is annulled |
| excValid | output | 1 | Exception accepted this cycle |
| excPc | output | ADDR_W | Restart address for the exception |
| excInSlot | output | 1 | Faulting instruction occupied a delay slot |

## Verification
A next address that was loaded wrongly shows on `pc` within two edges, because it becomes the current address after one shift. A wrong slot flag shows on `issueValid`, `excPc` or `excInSlot` in the very cycle the slot issues. A stale annul bit cancels, or fails to cancel, the next word at once. A lost branch address appears only when a slot faults, so the stimulus places faults inside slots and outside them. It also places faults under stall and in annulled slots, and follows each fault with the restart address on the next edge.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // Strobes sent from the sequencing control to the address datapath.
  typedef struct packed {
    logic advance;    // state may move this edge
    logic branch;     // an effective control transfer issues now
    logic useTarget;  // load the redirect into the next address
    logic replay;     // restart fetch at the exception address
    logic slotSel;    // current instruction is a delay slot
  } seqStrobesT;

endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stall,
  input  logic       isBranch,
  input  logic       brTaken,
  input  logic       brLikely,
  input  logic       fault,
  output seqStrobesT strobes,
  output logic       issueValid,
  output logic       excValid,
  output logic       excInSlot
);

  logic inSlot;
  logic annulSlot;
  logic faultLive;

  assign issueValid = !annulSlot;
  assign faultLive  = fault && !annulSlot;
  assign excValid   = faultLive && !stall;
  assign excInSlot  = excValid && inSlot;

  always_comb begin
    strobes           = '0;
    strobes.advance   = !stall;
    strobes.replay    = excValid;
    strobes.branch    = !stall && isBranch && !inSlot && !faultLive;
    strobes.useTarget = strobes.branch && brTaken;
    strobes.slotSel   = inSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSlot    <= 1'b0;
      annulSlot <= 1'b0;
    end else if (strobes.advance) begin
      if (strobes.replay) begin
        inSlot    <= 1'b0;
        annulSlot <= 1'b0;
      end else if (strobes.branch) begin
        inSlot    <= 1'b1;
        annulSlot <= brLikely && !brTaken;
      end else begin
        inSlot    <= 1'b0;
        annulSlot <= 1'b0;
      end
    end
  end

  AST_ANNUL_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN) annulSlot |-> inSlot); // R4
  AST_ANNUL_NO_EXC: assert property (@(posedge clk) disable iff (!rstN) !issueValid |-> !excValid); // R4
  AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) strobes.branch |=> inSlot && (annulSlot == $past(brLikely && !brTaken))); // R3
  AST_NESTED_PLAIN: assert property (@(posedge clk) disable iff (!rstN) (inSlot && !stall) |=> !inSlot); // R5
  AST_STALL_FLAGS: assert property (@(posedge clk) disable iff (!rstN) stall |=> $stable(inSlot) && $stable(annulSlot)); // R8

endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobesT        strobes,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] excPc
);

  localparam int unsigned STEP_BYTES = 4;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(STEP - 1'b1);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] npcReg;
  logic [ADDR_W-1:0] branchPc;
  logic [ADDR_W-1:0] alignedTarget;

  assign alignedTarget = target & ALIGN_MASK;
  assign excPc         = strobes.slotSel ? branchPc : pcReg;
  assign pc            = pcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= RESET_VEC;
      npcReg   <= RESET_VEC + STEP;
      branchPc <= RESET_VEC;
    end else if (strobes.replay) begin
      pcReg  <= excPc;
      npcReg <= excPc + STEP;
    end else if (strobes.branch) begin
      branchPc <= pcReg;
      pcReg    <= npcReg;
      npcReg   <= strobes.useTarget ? alignedTarget : npcReg + STEP;
    end else if (strobes.advance) begin
      pcReg  <= npcReg;
      npcReg <= npcReg + STEP;
    end
  end

  AST_PC_FROM_NPC: assert property (@(posedge clk) disable iff (!rstN) (strobes.advance && !strobes.replay) |=> pcReg == $past(npcReg)); // R2
  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rstN) strobes.useTarget |=> npcReg == ($past(target) & ALIGN_MASK)); // R3
  AST_REPLAY_ADDR: assert property (@(posedge clk) disable iff (!rstN) strobes.replay |=> pcReg == $past(excPc)); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN) !strobes.advance |=> $stable(pcReg) && $stable(npcReg)); // R8
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rstN) (pcReg[1:0] == 2'b00) && (npcReg[1:0] == 2'b00)); // R9

endmodule

// File: rtl/delay_pc_sequencer.sv
module delay_pc_sequencer
  import dps_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              isBranch,
  input  logic              brTaken,
  input  logic              brLikely,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              fault,
  output logic [ADDR_W-1:0] pc,
  output logic              issueValid,
  output logic              excValid,
  output logic [ADDR_W-1:0] excPc,
  output logic              excInSlot
);

  seqStrobesT strobes;

  dps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stall      (stall),
    .isBranch   (isBranch),
    .brTaken    (brTaken),
    .brLikely   (brLikely),
    .fault      (fault),
    .strobes    (strobes),
    .issueValid (issueValid),
    .excValid   (excValid),
    .excInSlot  (excInSlot)
  );

  dps_datapath #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .target  (brTarget),
    .pc      (pc),
    .excPc   (excPc)
  );

endmodule

// File: tb/delay_pc_sequencer_bench.sv
module delay_pc_sequencer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0, isBranch = 1'b0, brTaken = 1'b0, brLikely = 1'b0, fault = 1'b0;
  logic [31:0] brTarget = '0;
  logic [31:0] pc, excPc;
  logic        issueValid, excValid, excInSlot;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  delay_pc_sequencer u_delay_pc_sequencer (
    .clk(clk), .rstN(rstN), .stall(stall), .isBranch(isBranch), .brTaken(brTaken),
    .brLikely(brLikely), .brTarget(brTarget), .fault(fault), .pc(pc),
    .issueValid(issueValid), .excValid(excValid), .excPc(excPc), .excInSlot(excInSlot)
  );

  typedef struct packed {
    logic        stl, br, tk, lk, flt;
    logic [31:0] tgt;
    logic [31:0] ePc;
    logic        eVal, eExc;
    logic [31:0] eExcPc;
    logic        eSlot;
    logic [3:0]  req;
  } rowT;

  localparam int ROWS = 25;
  localparam rowT VECS [ROWS] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1000,1'b1,1'b0,32'h0,1'b0,4'd1}, // R1 reset vector
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1004,1'b1,1'b0,32'h0,1'b0,4'd2}, // R2
    '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h2000,32'h1008,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3 taken
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h100C,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3 slot
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h2000,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3 target
    '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h3000,32'h2004,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3 not taken
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h2008,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3 slot issues
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h200C,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3 fall-through
    '{1'b0,1'b1,1'b0,1'b1,1'b0,32'h3000,32'h2010,1'b1,1'b0,32'h0,1'b0,4'd4}, // R4 annulling, not taken
    '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,   32'h2014,1'b0,1'b0,32'h0,1'b0,4'd4}, // R4 annulled slot, fault ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h2018,1'b1,1'b0,32'h0,1'b0,4'd4}, // R4
    '{1'b0,1'b1,1'b1,1'b1,1'b0,32'h3001,32'h201C,1'b1,1'b0,32'h0,1'b0,4'd9}, // R9 unaligned target
    '{1'b1,1'b0,1'b0,1'b0,1'b1,32'h0,   32'h2020,1'b1,1'b0,32'h0,1'b0,4'd8}, // R8 stall masks fault
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h2020,1'b1,1'b0,32'h0,1'b0,4'd4}, // R4 taken slot valid
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h3000,1'b1,1'b0,32'h0,1'b0,4'd9}, // R9 aligned target
    '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h4000,32'h3004,1'b1,1'b0,32'h0,1'b0,4'd3}, // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h5000,32'h3008,1'b1,1'b0,32'h0,1'b0,4'd5}, // R5 branch in slot
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h4000,1'b1,1'b0,32'h0,1'b0,4'd5}, // R5 older target wins
    '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h6000,32'h4004,1'b1,1'b0,32'h0,1'b0,4'd6}, // R6 branch
    '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,   32'h4008,1'b1,1'b1,32'h4004,1'b1,4'd6}, // R6 slot fault
    '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h6000,32'h4004,1'b1,1'b0,32'h0,1'b0,4'd6}, // R6 restart at branch
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h4008,1'b1,1'b0,32'h0,1'b0,4'd6}, // R6 slot again
    '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,   32'h6000,1'b1,1'b1,32'h6000,1'b0,4'd7}, // R7 plain fault
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h6000,1'b1,1'b0,32'h0,1'b0,4'd7}, // R7 replay same pc
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h6004,1'b1,1'b0,32'h0,1'b0,4'd2}  // R2
  };

  task automatic drive(input logic s, b, t, l, f, input logic [31:0] tg);
    stall = s; isBranch = b; brTaken = t; brLikely = l; fault = f; brTarget = tg;
  endtask

  task automatic expect_out(input int req, input logic [31:0] ePc, input logic eVal,
                            input logic eExc, input logic [31:0] eExcPc, input logic eSlot);
    bit bad;
    checks++;
    bad = (pc !== ePc) || (issueValid !== eVal) || (excValid !== eExc) ||
          (eExc && ((excPc !== eExcPc) || (excInSlot !== eSlot))) || (!eExc && excInSlot !== 1'b0);
    if (bad) begin
      failures++;
      $display("FAIL R%0d: pc=%h val=%b exc=%b excPc=%h slot=%b expected pc=%h val=%b exc=%b excPc=%h slot=%b",
               req, pc, issueValid, excValid, excPc, excInSlot, ePc, eVal, eExc, eExcPc, eSlot);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 expect_out(1, 32'h1000, 1'b1, 1'b0, 32'h0, 1'b0);  // R1 during reset
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < ROWS; i++) begin
      drive(VECS[i].stl, VECS[i].br, VECS[i].tk, VECS[i].lk, VECS[i].flt, VECS[i].tgt);
      #1 expect_out(int'(VECS[i].req), VECS[i].ePc, VECS[i].eVal, VECS[i].eExc, VECS[i].eExcPc, VECS[i].eSlot);
      @(negedge clk);
    end

    // R1: reset mid-run returns to the vector at once
    drive(0, 0, 0, 0, 0, 32'h0);
    rstN = 1'b0;
    #1 expect_out(1, 32'h1000, 1'b1, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    #1 expect_out(1, 32'h1000, 1'b1, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    #1 expect_out(1, 32'h1004, 1'b1, 1'b0, 32'h0, 1'b0);

    // R4 + R8: annulled slot held across a stall keeps its annul state
    drive(0, 1, 0, 1, 0, 32'h8000);
    @(negedge clk);
    drive(1, 1, 1, 0, 1, 32'h9000);
    #1 expect_out(8, 32'h1008, 1'b0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    #1 expect_out(8, 32'h1008, 1'b0, 1'b0, 32'h0, 1'b0);
    drive(0, 1, 1, 0, 1, 32'h9000);
    #1 expect_out(4, 32'h1008, 1'b0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 32'h0);
    #1 expect_out(4, 32'h100C, 1'b1, 1'b0, 32'h0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule